// File: doc/BRIEF.md
# Dual-Port GPIO with Bit-Banged Flash and Sensor Pins

This block is a memory-mapped general-purpose I/O unit with two ports, A and D. Each port has three registers: an output value, an input view and an output enable. Software reaches them over a simple 32-bit register bus. The bus has a byte address, a write strobe, write data and combinational read data. The register window spans 0x5C bytes and takes whole-word accesses only, so the two low address bits play no part.

Three bits of port A's output register drive the control strobes of an external NAND flash. The flash ready line comes back on the port A input view. Two bits of port D's output register bit-bang a serial temperature sensor, one as clock and one as data. Whenever a write flips the stored clock bit, the block emits a one-cycle edge strobe that carries the new clock level. The sensor's serial output comes back on the port D input view. Every other word in the window is plain read/write storage.

Top module: `gpio_bitbang_port`

## Requirements
- R1: While reset is held, and on leaving it, every stored word is zero. The flash strobes, the sensor clock, the sensor data and the edge strobe are all low.
- R2: The register index is the byte address with its two low bits dropped, that is, address bits [6:2]. Indices 0 through 22 exist. A read of index 23 or above returns zero, and a write to one changes nothing.
- R3: Every existing index other than the two input views (0x01 and 0x11) reads back the last word written to it, in the same cycle as the address is presented.
- R4: A read of index 0x01 returns the word at 0x00 ANDed with the word at 0x02, with bit 7 ORed with the flash ready input. A read of index 0x11 returns the word at 0x10 ANDed with the word at 0x12, with bit 4 ORed with the sensor serial input.
- R5: The flash address-latch strobe follows bit 6 of the stored word at index 0x00. The command-latch strobe follows bit 5 and the chip-enable strobe follows bit 4. Each takes its new value in the cycle after the write.
- R6: The sensor clock output follows bit 1 of the stored word at index 0x10, and the sensor data output follows bit 4 of that word.
- R7: A write to index 0x10 whose bit 1 differs from the stored bit 1 raises the edge strobe for exactly the following cycle. The edge polarity equals the new sensor clock level. A write to 0x10 that leaves bit 1 unchanged raises no strobe, and neither does a write to any other index.
- R8: Writes to indices 0x01 and 0x11 have no effect on any value read back or on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 7 | Byte address; bits [6:2] select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| nand_ready_i | input | 1 | Flash ready line |
| sens_sdo_i | input | 1 | Sensor serial output |
| nand_ale_o | output | 1 | Flash address-latch strobe |
| nand_cle_o | output | 1 | Flash command-latch strobe |
| nand_ce_o | output | 1 | Flash chip-enable strobe |
| sens_clk_o | output | 1 | Sensor clock level |
| sens_sdi_o | output | 1 | Sensor serial data toward the sensor |
| sens_edge_o | output | 1 | One-cycle strobe on a sensor clock change |

## Verification
A corrupted stored word shows up at the very next read of its index. If the word is one of the two output registers, it also shows up on the strobe or sensor pins one cycle after the faulty write. A wrong view of the stored clock bit produces a missing or spurious edge strobe in the cycle after a port D write. The bench's reference model predicts both the read data and every pin on every clock. So any divergence is reported in the cycle it first becomes visible, and there is no end-of-test scan.

// File: rtl/gpio_bitbang_port.sv
module gpio_bitbang_port #(
  parameter int SPAN_BYTES = 92,
  parameter int ADDR_W     = 7,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              nand_ready_i,
  input  logic              sens_sdo_i,
  output logic              nand_ale_o,
  output logic              nand_cle_o,
  output logic              nand_ce_o,
  output logic              sens_clk_o,
  output logic              sens_sdi_o,
  output logic              sens_edge_o
);

  localparam int NREGS = SPAN_BYTES / 4;
  localparam int IDX_W = ADDR_W - 2;

  localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NREGS);
  localparam logic [IDX_W-1:0] A_OUT = IDX_W'(0);
  localparam logic [IDX_W-1:0] A_IN  = IDX_W'(1);
  localparam logic [IDX_W-1:0] A_OE  = IDX_W'(2);
  localparam logic [IDX_W-1:0] D_OUT = IDX_W'(16);
  localparam logic [IDX_W-1:0] D_IN  = IDX_W'(17);
  localparam logic [IDX_W-1:0] D_OE  = IDX_W'(18);

  localparam int ALE_BIT  = 6;
  localparam int CLE_BIT  = 5;
  localparam int CE_BIT   = 4;
  localparam int RDY_BIT  = 7;
  localparam int SCLK_BIT = 1;
  localparam int SDAT_BIT = 4;
  localparam int SDO_BIT  = 4;

  logic [DATA_W-1:0] regs [NREGS];
  logic              edge_q;

  wire [IDX_W-1:0] idx      = bus_addr[ADDR_W-1:2];
  wire             in_range = idx < LIMIT;
  wire             is_view  = (idx == A_IN) || (idx == D_IN);
  wire             wr_ok    = bus_wr && in_range && !is_view;
  wire             unused_addr_lo = &{1'b0, bus_addr[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
      edge_q <= 1'b0;
    end else begin
      edge_q <= wr_ok && (idx == D_OUT) &&
                (bus_wdata[SCLK_BIT] != regs[D_OUT][SCLK_BIT]);
      if (wr_ok) regs[idx] <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (in_range) begin
      unique case (idx)
        A_IN: begin
          bus_rdata = regs[A_OUT] & regs[A_OE];
          bus_rdata[RDY_BIT] = bus_rdata[RDY_BIT] | nand_ready_i;
        end
        D_IN: begin
          bus_rdata = regs[D_OUT] & regs[D_OE];
          bus_rdata[SDO_BIT] = bus_rdata[SDO_BIT] | sens_sdo_i;
        end
        default: bus_rdata = regs[idx];
      endcase
    end
  end

  assign nand_ale_o  = regs[A_OUT][ALE_BIT];
  assign nand_cle_o  = regs[A_OUT][CLE_BIT];
  assign nand_ce_o   = regs[A_OUT][CE_BIT];
  assign sens_clk_o  = regs[D_OUT][SCLK_BIT];
  assign sens_sdi_o  = regs[D_OUT][SDAT_BIT];
  assign sens_edge_o = edge_q;

  assert_ale_follows_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && idx == A_OUT) |=> (nand_ale_o == $past(bus_wdata[ALE_BIT])));

  assert_strobes_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && idx == A_OUT) |=> $stable({nand_ale_o, nand_cle_o, nand_ce_o}));

  assert_edge_means_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sens_edge_o |-> (sens_clk_o != $past(sens_clk_o)));

  assert_no_edge_without_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && idx == D_OUT) |=> !sens_edge_o);

  assert_clk_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && idx == D_OUT) |=> $stable({sens_clk_o, sens_sdi_o}));

  assert_out_of_range_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range |-> (bus_rdata == '0));

endmodule

// File: tb/gpio_bitbang_port_bench.sv
module gpio_bitbang_port_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        nand_ready_i = 1'b0;
  logic        sens_sdo_i = 1'b0;
  logic        nand_ale_o, nand_cle_o, nand_ce_o;
  logic        sens_clk_o, sens_sdi_o, sens_edge_o;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  logic [31:0] mem [0:22];
  logic        ref_edge = 1'b0;

  always #10 clk = ~clk;

  gpio_bitbang_port u_gpio_bitbang_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .nand_ready_i(nand_ready_i), .sens_sdo_i(sens_sdo_i),
    .nand_ale_o(nand_ale_o), .nand_cle_o(nand_cle_o), .nand_ce_o(nand_ce_o),
    .sens_clk_o(sens_clk_o), .sens_sdi_o(sens_sdi_o), .sens_edge_o(sens_edge_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] model_read(input logic [6:0] a, input bit rdy, input bit sdo);
    int i = int'(a[6:2]);
    logic [31:0] v;
    if (i > 22) return 32'h0;
    if (i == 1) begin
      v = mem[0] & mem[2];
      v[7] = v[7] | rdy;
      return v;
    end
    if (i == 17) begin
      v = mem[16] & mem[18];
      v[4] = v[4] | sdo;
      return v;
    end
    return mem[i];
  endfunction

  function automatic string read_tag(input logic [6:0] a);
    int i = int'(a[6:2]);
    if (i > 22) return "R2 out-of-range read";
    if (i == 1 || i == 17) return "R4 R8 input view read";
    return "R3 storage read";
  endfunction

  task automatic check_pins(input string pre);
    check({pre, " R5 ale"}, {31'h0, nand_ale_o}, {31'h0, mem[0][6]});
    check({pre, " R5 cle"}, {31'h0, nand_cle_o}, {31'h0, mem[0][5]});
    check({pre, " R5 ce"},  {31'h0, nand_ce_o},  {31'h0, mem[0][4]});
    check({pre, " R6 sclk"}, {31'h0, sens_clk_o}, {31'h0, mem[16][1]});
    check({pre, " R6 sdat"}, {31'h0, sens_sdi_o}, {31'h0, mem[16][4]});
    check({pre, " R7 edge"}, {31'h0, sens_edge_o}, {31'h0, ref_edge});
  endtask

  task automatic step(input bit wr, input logic [6:0] a, input logic [31:0] d,
                      input bit rdy, input bit sdo);
    int i;
    @(negedge clk);
    check_pins("cycle");
    bus_wr = wr; bus_addr = a; bus_wdata = d; nand_ready_i = rdy; sens_sdo_i = sdo;
    #2;
    check(read_tag(a), bus_rdata, model_read(a, rdy, sdo));
    @(posedge clk);
    i = int'(a[6:2]);
    ref_edge = 1'b0;
    if (wr && i <= 22 && i != 1 && i != 17) begin
      if (i == 16) ref_edge = (mem[16][1] != d[1]);
      mem[i] = d;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [6:0] a;
    for (int k = 0; k < 23; k++) mem[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_pins("reset R1");
    for (int k = 0; k < 23; k++) begin
      bus_addr = 7'(k * 4);
      #1;
      check("R1 reset word", bus_rdata, 32'h0);
    end
    rst_n = 1'b1;
    step(0, 7'h00, 0, 0, 0);

    // R5: each strobe bit alone
    step(1, 7'h00, 32'h40, 0, 0);
    step(1, 7'h00, 32'h20, 0, 0);
    step(1, 7'h00, 32'h10, 0, 0);
    step(1, 7'h08, 32'hFFFF_FFFF, 0, 0);
    step(0, 7'h04, 0, 1, 0);   // R4 ready ORed in
    step(0, 7'h04, 0, 0, 0);
    // R8: write the input view, then read it back
    step(1, 7'h04, 32'hDEAD_BEEF, 0, 0);
    step(0, 7'h05, 0, 0, 0);
    step(1, 7'h44, 32'h1234_5678, 0, 1);
    step(0, 7'h46, 0, 0, 1);
    // R6, R7: toggle the sensor clock, repeat the same level, change data only
    step(1, 7'h48, 32'h0000_0012, 0, 0);
    step(1, 7'h40, 32'h0000_0002, 0, 0);
    step(1, 7'h40, 32'h0000_0012, 0, 0);
    step(1, 7'h40, 32'h0000_0010, 0, 0);
    step(1, 7'h40, 32'h0000_0000, 0, 0);
    step(0, 7'h44, 0, 0, 1);
    step(0, 7'h44, 0, 0, 0);
    // R2: beyond the window, and low address bits ignored
    step(1, 7'h5C, 32'hCAFE_F00D, 0, 0);
    step(0, 7'h5C, 0, 0, 0);
    step(0, 7'h7F, 0, 0, 0);
    step(1, 7'h27, 32'hA5A5_0001, 0, 0);
    step(0, 7'h24, 0, 0, 0);
    step(1, 7'h58, 32'h0BAD_0BAD, 0, 0);
    step(0, 7'h5A, 0, 0, 0);

    for (int n = 0; n < 3000; n++) begin
      case ($urandom_range(0, 7))
        0: a = 7'h00;
        1: a = 7'h04;
        2: a = 7'h08;
        3: a = 7'h40;
        4: a = 7'h44;
        5: a = 7'h48;
        6: a = 7'h40 | 7'($urandom_range(0, 3));
        default: a = 7'($urandom_range(0, 127));
      endcase
      step($urandom_range(0, 1) == 1, a, $urandom, $urandom_range(0, 1) == 1,
           $urandom_range(0, 1) == 1);
    end
    step(0, 7'h00, 0, 0, 0);
    finish_run();
  end

endmodule